// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Control

This block holds the output latch of a small general-purpose port and turns each latch bit into three pad driver enables: a strong sink, a brief strong source (boost) and a weak keeper source (hold). A latch bit at 0 sinks the pin hard and keeps sinking it. A latch bit at 1 leaves only the weak keeper, so the same pin serves as an input that any external driver can pull low. When a bit goes from 0 to 1, a boost pulse of fixed length first charges the pin quickly. After the pulse only the keeper stays on.

Software loads the latch in two ways: a whole-port write, or a single-bit write for set/clear operations. Read-modify-write code reads the latch value back on `latch_rd`. The pin levels come back on `pin_rd`, after a two-stage synchronizer. Any pin named in the `ALT_MASK` parameter can be handed to a peripheral output, such as a serial transmit line. The peripheral's value then drives the pin through the same sink, boost and hold scheme, gated by the latch bit.

A whole-port write or an alternate-output change is seen at the driver enables one clock after the edge that captures it. Pad resistances and register addressing belong to other blocks.

Top module: `qbport_ctl`

## Requirements
- R1: While reset is active, and right after it, every latch bit is 1. `pull_dn` is all 0, `pull_up_boost` is all 0, `pull_up_hold` is all 1, and `latch_rd` and `pin_rd` are all 1.
- R2: A latch bit loaded with 0 turns on its `pull_dn` bit and turns off its `pull_up_hold` bit one clock after the latch edge. The sink stays on until a 1 reaches that bit or reset occurs.
- R3: A 0-to-1 change of a pin's drive value turns on its `pull_up_boost` bit for exactly `PULSE_CYC` cycles (default 2). The pulse starts in the same cycle that `pull_up_hold` returns to 1, and `pull_up_hold` stays at 1 during and after the pulse.
- R4: Writing 1 to a bit that already holds 1 produces no boost pulse.
- R5: On a given pin, `pull_dn` is never on at the same time as `pull_up_boost` or `pull_up_hold`.
- R6: `pin_rd` shows `pin_in` delayed by `SYNC_STAGES` clocks (default 2).
- R7: A single-bit write changes only the latch bit at index `bit_sel` (0 is the LSB) to `bit_val`. Every other bit keeps its latch value whatever level its pin has. `latch_rd` returns the latch, never the pins.
- R8: A whole-port write (`wr_en`) loads all of `wr_data` on the next edge, and it wins over a single-bit write in the same cycle.
- R9: For a pin whose `ALT_MASK` bit is 1 and whose `alt_en` bit is 1, the drive value is the latch bit AND the `alt_out` bit. This drive value goes through the same sink, boost and hold scheme, and it leaves the latch unchanged.
- R10: A pin whose `ALT_MASK` bit is 0 ignores `alt_en` and `alt_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Whole-port latch write strobe |
| wr_data | input | W | Value for a whole-port write |
| bit_wr_en | input | 1 | Single-bit latch write strobe |
| bit_sel | input | SEL_W | Index of the latch bit for a single-bit write |
| bit_val | input | 1 | Value for a single-bit write |
| alt_en | input | W | Per-pin hand-over to the alternate output |
| alt_out | input | W | Per-pin alternate (peripheral) output value |
| pin_in | input | W | Raw pin levels from the pads |
| pull_dn | output | W | Strong sink enable, per pin |
| pull_up_boost | output | W | Momentary strong source enable, per pin |
| pull_up_hold | output | W | Weak keeper source enable, per pin |
| pin_rd | output | W | Synchronized pin levels |
| latch_rd | output | W | Latch contents, for read-modify-write |

## Verification
Some rules are checked by assertions on every cycle:
- the sink never overlaps a source;
- a boost pulse only starts after a cycle of sinking, and it never runs longer than its length;
- a sink with a low drive value persists;
- a whole-port write always wins;
- a single-bit write leaves the other bits alone;
- synchronized readback equals the pin level delayed by the stage count;
- an alternate low on an enabled pin always sinks.

Other behaviours need the bench's scenarios:
- the exact pulse length after a real 0-to-1 write;
- no pulse on a rewrite of 1;
- set/clear against a pin held low from outside;
- a pin outside the alternate mask ignoring its alternate inputs.

// File: rtl/qbport_pkg.sv
package qbport_pkg;

   // enables for one pad's three drivers
   typedef struct packed {
      logic sink;    // strong pulldown
      logic boost;   // momentary strong pullup
      logic hold;    // weak keeper pullup
   } pad_ctl_t;

   localparam int unsigned MAX_SYNC_STAGES = 4;
   localparam int unsigned MAX_PULSE_CYC   = 64;

   function automatic int unsigned cnt_width(input int unsigned top);
      return (top < 2) ? 1 : $clog2(top + 1);
   endfunction

endpackage

// File: rtl/qbport_latch.sv
module qbport_latch
   import qbport_pkg::*;
#(
   parameter int unsigned W     = 8,
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [W-1:0]     wr_data,
   input  logic             bit_wr_en,
   input  logic [SEL_W-1:0] bit_sel,
   input  logic             bit_val,
   output logic [W-1:0]     lat_q
);

   logic [W-1:0] sel_mask;

   always_comb begin
      sel_mask = '0;
      for (int i = 0; i < W; i++) begin
         if (int'(bit_sel) == i) sel_mask[i] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '1;
      end else if (wr_en) begin
         lat_q <= wr_data;
      end else if (bit_wr_en) begin
         lat_q <= (lat_q & ~sel_mask) | (sel_mask & {W{bit_val}});
      end
   end

   // R8: whole-port write wins and loads all bits
   a_r8_full_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (lat_q == $past(wr_data)));

   // R7: single-bit write leaves unselected bits alone
   a_r7_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_wr_en && !wr_en) |=>
         ((lat_q & ~$past(sel_mask)) == ($past(lat_q) & ~$past(sel_mask))));

endmodule

// File: rtl/qbport_sync.sv
module qbport_sync
   import qbport_pkg::*;
#(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_out
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '1;
      else        stg[0] <= d_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '1;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q_out = stg[STAGES-1];

   // warm-up count so the delayed comparison never reaches before reset
   logic [2:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   warm <= '0;
      else if (int'(warm) < STAGES) warm <= warm + 3'd1;
   end

   // R6: readback equals the pin level STAGES clocks earlier
   a_r6_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(warm) >= STAGES) |-> (q_out == $past(d_in, STAGES)));

endmodule

// File: rtl/qbport_pin.sv
module qbport_pin
   import qbport_pkg::*;
#(
   parameter int unsigned PULSE_CYC = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     drive,
   output pad_ctl_t ctl
);

   localparam int unsigned CW = cnt_width(PULSE_CYC);

   logic dq, dprev, rise, boost;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq    <= 1'b1;
         dprev <= 1'b1;
      end else begin
         dq    <= drive;
         dprev <= dq;
      end
   end

   assign rise = dq & ~dprev;

   if (PULSE_CYC == 1) begin : g_single
      assign boost = rise;
   end else begin : g_count
      logic [CW-1:0] left;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          left <= '0;
         else if (!dq)        left <= '0;
         else if (rise)       left <= CW'(PULSE_CYC - 1);
         else if (left != '0) left <= left - 1'b1;
      end
      assign boost = dq & (rise | (left != '0));

      // R3: a started pulse lasts at least two cycles
      a_r3_boost_min: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(ctl.boost) && drive) |=> ctl.boost);
   end

   assign ctl.sink  = ~dq;
   assign ctl.boost = boost;
   assign ctl.hold  = dq;

   // run length of the boost pulse, for the upper bound check
   logic [CW:0] run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         run <= '0;
      else if (ctl.boost) run <= run + 1'b1;
      else                run <= '0;
   end

   // R5: sink never together with either source
   a_r5_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl.sink && (ctl.boost || ctl.hold)));

   // R3 and R4: boost only begins right after a sinking cycle
   a_r4_boost_needs_sink: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl.boost) |-> $past(ctl.sink));

   // R3: pulse never exceeds its length
   a_r3_boost_max: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.boost |-> (int'(run) < PULSE_CYC));

   // R2: a sink with a low drive persists
   a_r2_sink_held: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.sink && !drive) |=> ctl.sink);

endmodule

// File: rtl/qbport_ctl.sv
module qbport_ctl
   import qbport_pkg::*;
#(
   parameter int unsigned W           = 8,
   parameter int unsigned PULSE_CYC   = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [W-1:0] ALT_MASK   = '1,
   localparam int unsigned SEL_W      = (W > 1) ? $clog2(W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [W-1:0]     wr_data,
   input  logic             bit_wr_en,
   input  logic [SEL_W-1:0] bit_sel,
   input  logic             bit_val,
   input  logic [W-1:0]     alt_en,
   input  logic [W-1:0]     alt_out,
   input  logic [W-1:0]     pin_in,
   output logic [W-1:0]     pull_dn,
   output logic [W-1:0]     pull_up_boost,
   output logic [W-1:0]     pull_up_hold,
   output logic [W-1:0]     pin_rd,
   output logic [W-1:0]     latch_rd
);

   // elaboration-time parameter checks
   if (W < 1 || W > 64) begin : g_bad_w
      $error("qbport_ctl: W out of range");
   end
   if (PULSE_CYC < 1 || PULSE_CYC > MAX_PULSE_CYC) begin : g_bad_pulse
      $error("qbport_ctl: PULSE_CYC out of range");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > MAX_SYNC_STAGES) begin : g_bad_sync
      $error("qbport_ctl: SYNC_STAGES out of range");
   end

   logic [W-1:0] lat_q;
   logic [W-1:0] alt_low;
   logic [W-1:0] drive;

   qbport_latch #(.W(W), .SEL_W(SEL_W)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .bit_wr_en (bit_wr_en),
      .bit_sel   (bit_sel),
      .bit_val   (bit_val),
      .lat_q     (lat_q)
   );

   // a peripheral can only pull its pin low; the latch still gates it
   assign alt_low = ALT_MASK & alt_en & ~alt_out;
   assign drive   = lat_q & ~alt_low;

   for (genvar i = 0; i < W; i++) begin : g_pin
      pad_ctl_t ctl;
      qbport_pin #(.PULSE_CYC(PULSE_CYC)) u_pin (
         .clk   (clk),
         .rst_n (rst_n),
         .drive (drive[i]),
         .ctl   (ctl)
      );
      assign pull_dn[i]       = ctl.sink;
      assign pull_up_boost[i] = ctl.boost;
      assign pull_up_hold[i]  = ctl.hold;
   end

   qbport_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_in),
      .q_out (pin_rd)
   );

   assign latch_rd = lat_q;

   // R9: an enabled alternate low always sinks on the next cycle
   a_r9_alt_low_sinks: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pull_dn & $past(alt_low)) == $past(alt_low)));

   // R10: pins outside the mask follow the latch alone
   a_r10_mask_ignores_alt: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pull_dn & ~ALT_MASK) == (~$past(lat_q) & ~ALT_MASK)));

endmodule

// File: tb/qbport_ctl_bench.sv
module qbport_ctl_bench;

   localparam int unsigned W     = 8;
   localparam int unsigned PULSE = 2;
   localparam logic [7:0]  AMASK = 8'h7F;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en, bit_wr_en, bit_val;
   logic [7:0] wr_data, alt_en, alt_out, pin_in;
   logic [2:0] bit_sel;
   logic [7:0] pull_dn, pull_up_boost, pull_up_hold, pin_rd, latch_rd;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   qbport_ctl #(.W(W), .PULSE_CYC(PULSE), .SYNC_STAGES(2), .ALT_MASK(AMASK)) u_qbport_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .wr_data       (wr_data),
      .bit_wr_en     (bit_wr_en),
      .bit_sel       (bit_sel),
      .bit_val       (bit_val),
      .alt_en        (alt_en),
      .alt_out       (alt_out),
      .pin_in        (pin_in),
      .pull_dn       (pull_dn),
      .pull_up_boost (pull_up_boost),
      .pull_up_hold  (pull_up_hold),
      .pin_rd        (pin_rd),
      .latch_rd      (latch_rd)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- scoreboard: predictor pushes, monitor pops
   typedef struct packed {
      logic [7:0] dn, bo, ho, pr, lr;
   } exp_t;
   exp_t exp_q[$];

   logic [7:0] m_lat = 8'hFF, m_drv = 8'hFF, m_s1 = 8'hFF, m_s2 = 8'hFF;
   int         m_left [8];

   always @(posedge clk) begin
      exp_t       e;
      logic [7:0] eff, bomask;
      if (!rst_n) begin
         m_lat = 8'hFF; m_drv = 8'hFF; m_s1 = 8'hFF; m_s2 = 8'hFF;
         for (int i = 0; i < 8; i++) m_left[i] = 0;
      end else begin
         eff = m_lat & ~(AMASK & alt_en & ~alt_out);
         for (int i = 0; i < 8; i++) begin
            if (!eff[i])              m_left[i] = 0;
            else if (!m_drv[i])       m_left[i] = PULSE;
            else if (m_left[i] > 0)   m_left[i] = m_left[i] - 1;
         end
         m_drv = eff;
         if (wr_en)          m_lat = wr_data;
         else if (bit_wr_en) m_lat[bit_sel] = bit_val;
         m_s2 = m_s1;
         m_s1 = pin_in;
      end
      bomask = '0;
      for (int i = 0; i < 8; i++) bomask[i] = (m_left[i] > 0);
      e.dn = ~m_drv; e.bo = bomask; e.ho = m_drv; e.pr = m_s2; e.lr = m_lat;
      exp_q.push_back(e);
   end

   always @(negedge clk) begin
      exp_t e;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         chk("R2 scoreboard pull_dn",       pull_dn,       e.dn);
         chk("R3 scoreboard pull_up_boost", pull_up_boost, e.bo);
         chk("R3 scoreboard pull_up_hold",  pull_up_hold,  e.ho);
         chk("R6 scoreboard pin_rd",        pin_rd,        e.pr);
         chk("R7 scoreboard latch_rd",      latch_rd,      e.lr);
         chk("R5 scoreboard no fight",      pull_dn & (pull_up_boost | pull_up_hold), 8'h00);
      end
   end

   // ---------------- stimulus helpers (drive just after the falling edge)
   task automatic tick();
      @(negedge clk);
      wr_en     = 1'b0;
      bit_wr_en = 1'b0;
   endtask

   task automatic port_write(input logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_data = v; bit_wr_en = 1'b0;
   endtask

   task automatic bit_write(input logic [2:0] s, input logic v);
      @(negedge clk);
      bit_wr_en = 1'b1; bit_sel = s; bit_val = v; wr_en = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; bit_wr_en = 1'b0;
      bit_sel = '0; bit_val = 1'b0; alt_en = '0; alt_out = '0; pin_in = 8'hFF;
      repeat (3) @(negedge clk);
      chk("R1 reset pull_dn",  pull_dn,       8'h00);
      chk("R1 reset boost",    pull_up_boost, 8'h00);
      chk("R1 reset hold",     pull_up_hold,  8'hFF);
      chk("R1 reset latch_rd", latch_rd,      8'hFF);
      chk("R1 reset pin_rd",   pin_rd,        8'hFF);
      rst_n = 1'b1;
      tick();

      // R2 / R8: write zeros into half the bits
      port_write(8'hA5);
      tick();
      chk("R8 latch loaded", latch_rd, 8'hA5);
      chk("R2 drivers one cycle later", pull_dn, 8'h00);
      tick();
      chk("R2 sink on", pull_dn, 8'h5A);
      chk("R2 hold off where sinking", pull_up_hold, 8'hA5);
      chk("R4 no boost on kept ones", pull_up_boost, 8'h00);
      repeat (4) tick();
      chk("R2 sink held", pull_dn, 8'h5A);

      // R3: 0 to 1 gives a two-cycle boost
      port_write(8'hFF);
      tick();
      tick();
      chk("R3 boost first cycle", pull_up_boost, 8'h5A);
      chk("R3 hold back on", pull_up_hold, 8'hFF);
      tick();
      chk("R3 boost second cycle", pull_up_boost, 8'h5A);
      tick();
      chk("R3 boost ended", pull_up_boost, 8'h00);
      chk("R3 hold remains", pull_up_hold, 8'hFF);

      // R4: rewrite of ones
      port_write(8'hFF);
      tick();
      tick();
      chk("R4 rewrite no boost", pull_up_boost, 8'h00);
      tick();
      chk("R4 rewrite no boost later", pull_up_boost, 8'h00);

      // R6: synchronizer delay
      @(negedge clk);
      pin_in = 8'h0F;
      tick();
      chk("R6 not yet after one clock", pin_rd, 8'hFF);
      tick();
      chk("R6 visible after two clocks", pin_rd, 8'h0F);

      // R7: bit clear while upper pins are held low from outside
      bit_write(3'd1, 1'b0);
      tick();
      chk("R7 only selected bit cleared", latch_rd, 8'hFD);
      tick();
      chk("R7 sink on selected pin", pull_dn, 8'h02);
      bit_write(3'd1, 1'b1);
      tick();
      chk("R7 bit set back", latch_rd, 8'hFF);
      tick();
      chk("R7 boost on selected pin", pull_up_boost, 8'h02);
      repeat (3) tick();

      // R8: whole write beats bit write
      @(negedge clk);
      wr_en = 1'b1; wr_data = 8'h3C; bit_wr_en = 1'b1; bit_sel = 3'd0; bit_val = 1'b1;
      tick();
      chk("R8 whole write wins", latch_rd, 8'h3C);
      port_write(8'hFF);
      repeat (4) tick();
      pin_in = 8'hFF;

      // R9: alternate output on pin 0
      @(negedge clk);
      alt_en = 8'h01; alt_out = 8'h00;
      tick();
      chk("R9 alt low sinks", pull_dn, 8'h01);
      chk("R9 latch untouched", latch_rd, 8'hFF);
      alt_out = 8'h01;
      tick();
      chk("R9 alt rise boosts", pull_up_boost, 8'h01);
      alt_en = 8'h00;
      repeat (3) tick();

      // R10: pin 7 is outside the alternate mask
      @(negedge clk);
      alt_en = 8'h80; alt_out = 8'h00;
      tick();
      chk("R10 masked pin ignores alt", pull_dn, 8'h00);
      tick();
      chk("R10 masked pin still high", pull_up_hold, 8'hFF);
      alt_en = 8'h00;
      repeat (3) tick();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule